// File: doc/BRIEF.md
# Cycle-Steal Request Controller

This block is the device-side sequencer for storage-access transfers that a device takes from the processor by cycle stealing. Software-side logic loads a start address, a transfer count, a direction and a burst flag while the block is idle. The device then asks for service, and the block raises its cycle-steal request line. That line stays up until the device captures a poll or a hard abort arrives. Once the poll is captured, the block runs one transfer, or a whole burst in burst mode. On each completed transfer it steps the address and count.

A device-directed reset cannot withdraw a request that is already on the interface. The outstanding request is still carried through to a poll capture and is then serviced as a dummy transfer. A dummy transfer always reads from storage. During it the address and count are frozen and no status strobe is given. In burst mode, a device reset during the burst turns the transfer in flight into the dummy, which is then the last transfer of the burst. When the dummy completes, the block is idle and its parameter registers hold zero. A halt or machine check, a system reset, or a power-on reset aborts at once with no dummy transfer.

Top module: `cs_req_ctrl`

## Requirements
- R1: After reset, cs_req_o, xfer_o, dummy_o, rd_o and status_we_o are 0, and addr_o and cnt_o are 0.
- R2: need_i seen while idle raises cs_req_o on the next cycle. cs_req_o then stays at 1 until poll_cap_i is seen or a hard abort arrives, and a device reset does not lower it.
- R3: A poll capture of a normal request gives cs_req_o=0, xfer_o=1 and dummy_o=0 on the next cycle. rd_o then equals the loaded direction, where 1 means a read from storage.
- R4: xfer_done_i during a normal transfer pulses status_we_o in the same cycle. On the next cycle addr_o has grown by STEP (modulo 2^AW) and cnt_o has dropped by one, staying at 0 if it was already 0.
- R5: In burst mode, transfers continue while cnt_o is above 1 at xfer_done_i. Without burst mode, or once cnt_o is 1 or 0 at xfer_done_i, the block returns to idle and xfer_o falls on the next cycle.
- R6: halt_i, sys_rst_i or por_i in any state gives cs_req_o=0, xfer_o=0, dummy_o=0 and addr_o=cnt_o=0 on the next cycle.
- R7: After a device reset of a pending request, the next poll capture starts a dummy transfer with xfer_o=1, dummy_o=1 and rd_o=1, whatever direction was loaded.
- R8: A device reset during a burst transfer turns that transfer into a dummy on the next cycle, and no transfer follows its completion.
- R9: While a dummy is pending or in progress, status_we_o stays 0 and addr_o and cnt_o do not change.
- R10: xfer_done_i during a dummy transfer returns the block to idle on the next cycle, with xfer_o=0 and addr_o=cnt_o=0.
- R11: A device reset while idle clears addr_o and cnt_o, and it blocks a need_i given in the same cycle, so cs_req_o stays 0.
- R12: load_i is ignored outside idle: addr_o and cnt_o keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load start parameters (idle only) |
| start_addr_i | input | AW | Start storage address |
| start_cnt_i | input | CW | Number of transfers |
| dir_rd_i | input | 1 | Direction for normal transfers, 1 = read from storage |
| burst_i | input | 1 | Burst mode for the loaded job |
| need_i | input | 1 | Device needs a storage access |
| poll_cap_i | input | 1 | Device captured a poll |
| xfer_done_i | input | 1 | Current transfer finished |
| dev_rst_i | input | 1 | Device-directed reset |
| halt_i | input | 1 | Halt or machine check |
| sys_rst_i | input | 1 | System reset |
| por_i | input | 1 | Power-on reset |
| cs_req_o | output | 1 | Cycle-steal request line |
| xfer_o | output | 1 | Transfer in progress |
| dummy_o | output | 1 | Current transfer is a dummy |
| rd_o | output | 1 | Transfer direction, 1 = read from storage |
| status_we_o | output | 1 | Status record strobe for a completed real transfer |
| addr_o | output | AW | Current address parameter |
| cnt_o | output | CW | Remaining count parameter |

## Verification
Every state-derived output (cs_req_o, xfer_o, dummy_o, rd_o, addr_o, cnt_o) moves one clock edge after the input that causes it, because only one register lies between inputs and these outputs. status_we_o is decoded from the state and xfer_done_i, so it is valid in the same cycle as the done. The bench drives inputs just after a falling edge. It samples registered results at the following falling edge, and it samples the strobe one nanosecond after driving, before the rising edge that consumes it.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic [2:0] {
    CS_IDLE  = 3'd0,
    CS_REQ   = 3'd1,
    CS_XFER  = 3'd2,
    CS_DPEND = 3'd3,
    CS_DXFER = 3'd4
  } cs_state_t;
endpackage

// File: rtl/cs_fsm.sv
module cs_fsm
  import cs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hard_abort,
  input  logic      dev_rst,
  input  logic      need,
  input  logic      poll_cap,
  input  logic      xfer_done,
  input  logic      burst,
  input  logic      cnt_gt1,
  output cs_state_t state,
  output logic      upd,
  output logic      clr
);
  cs_state_t nxt;

  always_comb begin
    nxt = state;
    upd = 1'b0;
    clr = 1'b0;
    if (hard_abort) begin
      nxt = CS_IDLE;
      clr = 1'b1;
    end else begin
      unique case (state)
        CS_IDLE: begin
          if (dev_rst) clr = 1'b1;
          else if (need) nxt = CS_REQ;
        end
        CS_REQ: begin
          if (dev_rst) nxt = poll_cap ? CS_DXFER : CS_DPEND;
          else if (poll_cap) nxt = CS_XFER;
        end
        CS_DPEND: begin
          if (poll_cap) nxt = CS_DXFER;
        end
        CS_XFER: begin
          if (dev_rst) begin
            if (xfer_done) begin
              nxt = CS_IDLE;
              clr = 1'b1;
            end else begin
              nxt = CS_DXFER;
            end
          end else if (xfer_done) begin
            upd = 1'b1;
            nxt = (burst && cnt_gt1) ? CS_XFER : CS_IDLE;
          end
        end
        CS_DXFER: begin
          if (xfer_done) begin
            nxt = CS_IDLE;
            clr = 1'b1;
          end
        end
        default: begin
          nxt = CS_IDLE;
          clr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= CS_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/cs_param_regs.sv
module cs_param_regs #(
  parameter int AW   = 16,
  parameter int CW   = 8,
  parameter int STEP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic          upd,
  input  logic          clr,
  input  logic [AW-1:0] ld_addr,
  input  logic [CW-1:0] ld_cnt,
  input  logic          ld_dir,
  input  logic          ld_burst,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] cnt,
  output logic          dir_rd,
  output logic          burst,
  output logic          cnt_gt1
);
  localparam logic [AW-1:0] ADDR_INC = AW'(STEP);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  logic          en;
  logic [AW-1:0] addr_d;
  logic [CW-1:0] cnt_d;
  logic          dir_d;
  logic          burst_d;

  assign en = clr | ld | upd;

  always_comb begin
    addr_d  = addr;
    cnt_d   = cnt;
    dir_d   = dir_rd;
    burst_d = burst;
    if (clr) begin
      addr_d  = '0;
      cnt_d   = '0;
      dir_d   = 1'b0;
      burst_d = 1'b0;
    end else if (ld) begin
      addr_d  = ld_addr;
      cnt_d   = ld_cnt;
      dir_d   = ld_dir;
      burst_d = ld_burst;
    end else if (upd) begin
      addr_d = addr + ADDR_INC;
      cnt_d  = (cnt == '0) ? '0 : cnt - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      cnt    <= '0;
      dir_rd <= 1'b0;
      burst  <= 1'b0;
    end else if (en) begin
      addr   <= addr_d;
      cnt    <= cnt_d;
      dir_rd <= dir_d;
      burst  <= burst_d;
    end
  end

  assign cnt_gt1 = (cnt > CNT_ONE);
endmodule

// File: rtl/cs_req_ctrl.sv
module cs_req_ctrl
  import cs_pkg::*;
#(
  parameter int AW   = 16,
  parameter int CW   = 8,
  parameter int STEP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [CW-1:0] start_cnt_i,
  input  logic          dir_rd_i,
  input  logic          burst_i,
  input  logic          need_i,
  input  logic          poll_cap_i,
  input  logic          xfer_done_i,
  input  logic          dev_rst_i,
  input  logic          halt_i,
  input  logic          sys_rst_i,
  input  logic          por_i,
  output logic          cs_req_o,
  output logic          xfer_o,
  output logic          dummy_o,
  output logic          rd_o,
  output logic          status_we_o,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] cnt_o
);
  cs_state_t state;
  logic      hard_abort, upd, clr, ld;
  logic      dir_q, burst_q, cnt_gt1;

  assign hard_abort = halt_i | sys_rst_i | por_i;
  assign ld         = load_i & (state == CS_IDLE) & ~hard_abort;

  cs_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .hard_abort (hard_abort),
    .dev_rst    (dev_rst_i),
    .need       (need_i),
    .poll_cap   (poll_cap_i),
    .xfer_done  (xfer_done_i),
    .burst      (burst_q),
    .cnt_gt1    (cnt_gt1),
    .state      (state),
    .upd        (upd),
    .clr        (clr)
  );

  cs_param_regs #(.AW(AW), .CW(CW), .STEP(STEP)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld       (ld),
    .upd      (upd),
    .clr      (clr),
    .ld_addr  (start_addr_i),
    .ld_cnt   (start_cnt_i),
    .ld_dir   (dir_rd_i),
    .ld_burst (burst_i),
    .addr     (addr_o),
    .cnt      (cnt_o),
    .dir_rd   (dir_q),
    .burst    (burst_q),
    .cnt_gt1  (cnt_gt1)
  );

  assign cs_req_o    = (state == CS_REQ) | (state == CS_DPEND);
  assign xfer_o      = (state == CS_XFER) | (state == CS_DXFER);
  assign dummy_o     = (state == CS_DXFER);
  assign rd_o        = (state == CS_DXFER) | ((state == CS_XFER) & dir_q);
  assign status_we_o = upd;
endmodule

// File: rtl/cs_req_ctrl_chk.sv
module cs_req_ctrl_chk #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          poll_cap_i,
  input logic          xfer_done_i,
  input logic          halt_i,
  input logic          sys_rst_i,
  input logic          por_i,
  input logic          cs_req_o,
  input logic          xfer_o,
  input logic          dummy_o,
  input logic          rd_o,
  input logic          status_we_o,
  input logic [AW-1:0] addr_o,
  input logic [CW-1:0] cnt_o
);
  logic abort_any;
  assign abort_any = halt_i | sys_rst_i | por_i;

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_req_o && !poll_cap_i && !abort_any |=> cs_req_o);

  // R6
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_any |=> !cs_req_o && !xfer_o && !dummy_o && addr_o == '0 && cnt_o == '0);

  // R7
  dummy_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dummy_o |-> rd_o && xfer_o);

  // R9
  dummy_no_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dummy_o |-> !status_we_o);

  // R9
  dummy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dummy_o && !xfer_done_i && !abort_any |=> $stable(addr_o) && $stable(cnt_o));

  // R10
  dummy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dummy_o && xfer_done_i |=> !xfer_o && addr_o == '0 && cnt_o == '0);

  // R3
  req_xfer_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_req_o && xfer_o));
endmodule

bind cs_req_ctrl cs_req_ctrl_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .poll_cap_i  (poll_cap_i),
  .xfer_done_i (xfer_done_i),
  .halt_i      (halt_i),
  .sys_rst_i   (sys_rst_i),
  .por_i       (por_i),
  .cs_req_o    (cs_req_o),
  .xfer_o      (xfer_o),
  .dummy_o     (dummy_o),
  .rd_o        (rd_o),
  .status_we_o (status_we_o),
  .addr_o      (addr_o),
  .cnt_o       (cnt_o)
);

// File: tb/sim_cs_req_ctrl.sv
`timescale 1ns/1ps
module sim_cs_req_ctrl;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam int STEP = 2;
  localparam int NV = 5;
  // {addr, cnt, dir, burst}
  localparam logic [25:0] VEC [NV] = '{
    {16'h1000, 8'd3, 1'b1, 1'b0},
    {16'h2000, 8'd4, 1'b0, 1'b1},
    {16'h3000, 8'd1, 1'b1, 1'b1},
    {16'h4000, 8'd0, 1'b0, 1'b1},
    {16'hFFFE, 8'd2, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic load_i, dir_rd_i, burst_i, need_i, poll_cap_i, xfer_done_i;
  logic dev_rst_i, halt_i, sys_rst_i, por_i;
  logic [AW-1:0] start_addr_i;
  logic [CW-1:0] start_cnt_i;
  logic cs_req_o, xfer_o, dummy_o, rd_o, status_we_o;
  logic [AW-1:0] addr_o;
  logic [CW-1:0] cnt_o;

  int total = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  cs_req_ctrl #(.AW(AW), .CW(CW), .STEP(STEP)) u0 (.*);

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      total++; fails++;
      $display("FAIL watchdog (all R) act=hung exp=finished");
      summary();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic load(input logic [AW-1:0] a, input logic [CW-1:0] c, input logic d, input logic b);
    load_i = 1'b1; start_addr_i = a; start_cnt_i = c; dir_rd_i = d; burst_i = b;
    tick();
    load_i = 1'b0;
  endtask

  task automatic raise_req();
    need_i = 1'b1;
    tick();
    need_i = 1'b0;
  endtask

  task automatic capture();
    poll_cap_i = 1'b1;
    tick();
    poll_cap_i = 1'b0;
  endtask

  task automatic pulse_abort(input int which);
    if (which == 0) halt_i = 1'b1;
    else if (which == 1) sys_rst_i = 1'b1;
    else por_i = 1'b1;
    tick();
    halt_i = 1'b0; sys_rst_i = 1'b0; por_i = 1'b0;
    chk("R6 req", cs_req_o, 0);
    chk("R6 xfer", xfer_o, 0);
    chk("R6 dummy", dummy_o, 0);
    chk("R6 addr", addr_o, 0);
    chk("R6 cnt", cnt_o, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    load_i = 0; dir_rd_i = 0; burst_i = 0; need_i = 0; poll_cap_i = 0; xfer_done_i = 0;
    dev_rst_i = 0; halt_i = 0; sys_rst_i = 0; por_i = 0;
    start_addr_i = '0; start_cnt_i = '0;
    tick(); tick(); tick();
    rst_n = 1'b1;
    tick();
    chk("R1 req", cs_req_o, 0);
    chk("R1 xfer", xfer_o, 0);
    chk("R1 dummy", dummy_o, 0);
    chk("R1 rd", rd_o, 0);
    chk("R1 stat", status_we_o, 0);
    chk("R1 addr", addr_o, 0);
    chk("R1 cnt", cnt_o, 0);

    // Table walk: full normal jobs
    for (int i = 0; i < NV; i++) begin
      logic [AW-1:0] ea;
      logic [CW-1:0] ec;
      logic ed, eb, more;
      {ea, ec, ed, eb} = VEC[i];
      load(ea, ec, ed, eb);
      raise_req();
      chk("R2 raise", cs_req_o, 1);
      tick(); tick();
      chk("R2 hold", cs_req_o, 1);
      capture();
      chk("R3 req low", cs_req_o, 0);
      chk("R3 xfer", xfer_o, 1);
      chk("R3 dummy", dummy_o, 0);
      chk("R3 dir", rd_o, ed);
      more = 1'b1;
      while (more) begin
        tick();
        xfer_done_i = 1'b1;
        #1;
        chk("R4 strobe", status_we_o, 1);
        more = eb && (ec > 1);
        tick();
        xfer_done_i = 1'b0;
        ea = ea + AW'(STEP);
        ec = (ec == 0) ? '0 : ec - 1'b1;
        chk("R4 addr", addr_o, ea);
        chk("R4 cnt", cnt_o, ec);
        chk("R5 continue", xfer_o, more);
      end
    end

    // R12: load ignored while transferring
    load(16'h0500, 8'd6, 1'b0, 1'b1);
    raise_req();
    capture();
    load(16'h7777, 8'd9, 1'b1, 1'b0);
    chk("R12 addr", addr_o, 16'h0500);
    chk("R12 cnt", cnt_o, 6);
    pulse_abort(1);

    // R7/R9/R10: device reset of pending request
    load(16'h0800, 8'd3, 1'b0, 1'b0);
    raise_req();
    dev_rst_i = 1'b1;
    tick();
    dev_rst_i = 1'b0;
    chk("R2 dev rst keeps req", cs_req_o, 1);
    tick();
    chk("R2 req still", cs_req_o, 1);
    chk("R9 addr frozen", addr_o, 16'h0800);
    chk("R9 cnt frozen", cnt_o, 3);
    capture();
    chk("R7 xfer", xfer_o, 1);
    chk("R7 dummy", dummy_o, 1);
    chk("R7 read", rd_o, 1);
    chk("R7 req low", cs_req_o, 0);
    tick();
    xfer_done_i = 1'b1;
    #1;
    chk("R9 no strobe", status_we_o, 0);
    tick();
    xfer_done_i = 1'b0;
    chk("R10 idle", xfer_o, 0);
    chk("R10 dummy low", dummy_o, 0);
    chk("R10 addr", addr_o, 0);
    chk("R10 cnt", cnt_o, 0);

    // R8: device reset in middle of a burst
    load(16'h0100, 8'd5, 1'b0, 1'b1);
    raise_req();
    capture();
    xfer_done_i = 1'b1;
    tick();
    xfer_done_i = 1'b0;
    chk("R8 first real", addr_o, 16'h0102);
    dev_rst_i = 1'b1;
    tick();
    dev_rst_i = 1'b0;
    chk("R8 dummy", dummy_o, 1);
    chk("R8 read", rd_o, 1);
    chk("R9 addr kept", addr_o, 16'h0102);
    chk("R9 cnt kept", cnt_o, 4);
    xfer_done_i = 1'b1;
    #1;
    chk("R9 no strobe burst", status_we_o, 0);
    tick();
    xfer_done_i = 1'b0;
    chk("R8 ended", xfer_o, 0);
    tick();
    chk("R8 no more", xfer_o, 0);
    chk("R8 no req", cs_req_o, 0);
    chk("R10 burst addr", addr_o, 0);

    // R6: hard aborts in different states
    load(16'h0900, 8'd2, 1'b1, 1'b0);
    raise_req();
    pulse_abort(0);
    load(16'h0A00, 8'd2, 1'b1, 1'b1);
    raise_req();
    capture();
    pulse_abort(2);
    load(16'h0B00, 8'd2, 1'b1, 1'b0);
    raise_req();
    dev_rst_i = 1'b1;
    tick();
    dev_rst_i = 1'b0;
    pulse_abort(1);
    tick();
    chk("R6 no dummy later", xfer_o, 0);

    // R11: device reset while idle
    load(16'h0C00, 8'd7, 1'b1, 1'b0);
    chk("R11 loaded", addr_o, 16'h0C00);
    dev_rst_i = 1'b1; need_i = 1'b1;
    tick();
    dev_rst_i = 1'b0; need_i = 1'b0;
    chk("R11 no req", cs_req_o, 0);
    chk("R11 addr", addr_o, 0);
    chk("R11 cnt", cnt_o, 0);

    summary();
  end
endmodule